// File: doc/BRIEF.md
# Interruptible Vector Dot-Product Sequencer

This block walks two vectors stored in a synchronous memory, fetches one element pair per step, and adds each pair's product into a signed accumulator. A start command supplies both base addresses, the element count and a precision select. Single precision uses one 16-bit signed word per operand. Double precision uses two words per operand, forming a 32-bit signed value. Each run takes a fixed 10-cycle overhead plus 8 cycles per element in single precision or 16 cycles per element in double precision. A one-cycle done pulse marks the end of the run.

The run can be suspended at an element boundary. While suspended, the block keeps the element index and both vector pointers, issues no reads and leaves the accumulator untouched. A resume pulse continues the run with the next element. The accumulator is never cleared by a start command. A separate clear command resets it, so several runs can add into one sum.

Top module: `dp_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `held`, `done` and `mem_rd` are 0 and `acc` is 0.
- R2: In single precision (`dbl`=0), once a start is accepted from idle, `busy` is high for exactly 10 + 8·N consecutive active cycles, beginning the cycle after the start.
- R3: In double precision (`dbl`=1), `busy` is high for exactly 10 + 16·N active cycles.
- R4: In single precision, element i of vector A is the 16-bit signed word at `base_a`+i and element i of B is at `base_b`+i. A run adds the sum over i of A_i·B_i to `acc`.
- R5: In double precision, operand i of A is the 32-bit signed value formed from the word at `base_a`+2i (upper half) and the word at `base_a`+2i+1 (lower half). B is formed the same way from `base_b`. The run adds the sum of products to `acc`.
- R6: With N = 0, the run is busy for exactly 10 cycles, issues no read and leaves `acc` unchanged.
- R7: `done` is high for exactly one cycle per run, and that cycle is the last cycle in which `busy` is high.
- R8: If `intr_req` is high in the last cycle of an element and elements remain, the block enters a hold state. In hold, `held`=1, `busy`=0, there are no reads, and `acc` is frozen with the completed elements already included. A `resume` pulse continues with the next element. The final result and the active cycle count are the same as for an uninterrupted run.
- R9: A `start` that arrives while the block is busy or held is ignored, and the run's result and timing are unchanged.
- R10: `acc_clr` sets `acc` to 0 when the block is idle. It has no effect while the block is busy or held.
- R11: Memory data is taken the cycle after `mem_rd`. Each element uses exactly 2 reads in single precision and 4 reads in double precision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start command, accepted only when idle |
| base_a | input | AW | Base word address of vector A |
| base_b | input | AW | Base word address of vector B |
| len | input | LW | Element count N |
| dbl | input | 1 | 1 selects double precision |
| intr_req | input | 1 | Suspend request, sampled at element ends |
| resume | input | 1 | Continue a held run |
| acc_clr | input | 1 | Clear accumulator (idle only) |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Run active (not held) |
| held | output | 1 | Run suspended at an element boundary |
| done | output | 1 | One-cycle end-of-run pulse |
| acc | output | ACC_W | Signed accumulator |

## Verification
A wrong phase counter or a wrong element bound shows up as a `busy` window whose length differs from 10 plus the per-element budget. This is visible at the end of the very run in which the fault occurs. A wrong pointer advance, a swapped word half or a mis-sized sign extension corrupts `acc`, which is compared against a bench-computed sum at every run end. A hold that loses the saved index or pointers makes the resumed sum differ, and the partial sum is also checked at the moment the hold begins. Read counts and the `done` position expose pacing errors within a single run.

// File: rtl/dp_pkg.sv
// Shared types for the dot-product sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_ELEM,
        ST_HOLD,
        ST_TAIL
    } seq_state_t;
endpackage

// File: rtl/dp_addr_gen.sv
// Vector pointer pair and read-address select.
// Holds a pointer into each vector. Per element, word_sel walks the A words
// first and then the B words. The pointers survive a hold untouched.
// Assumes: word_sel < 2 in single precision and < 4 in double precision.
module dp_addr_gen #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic          dbl,
    input  logic [1:0]    word_sel,
    input  logic [AW-1:0] base_a,
    input  logic [AW-1:0] base_b,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] ptr_a, ptr_b;
    logic [AW-1:0] half;

    assign half = dbl ? AW'(2) : AW'(1);

    // Pointer registers: loaded on start, stepped by one element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_a <= '0;
            ptr_b <= '0;
        end else if (load) begin
            ptr_a <= base_a;
            ptr_b <= base_b;
        end else if (advance) begin
            ptr_a <= ptr_a + half;
            ptr_b <= ptr_b + half;
        end
    end

    // Address select: A words first, then B words.
    always_comb begin
        if (AW'(word_sel) < half)
            addr = ptr_a + AW'(word_sel);
        else
            addr = ptr_b + (AW'(word_sel) - half);
    end
endmodule

// File: rtl/dp_operand.sv
// Operand assembly from returning memory words.
// In single precision, word 0 is A and word 1 is B, each sign-extended.
// In double precision, words 0/1 are A upper/lower and words 2/3 are
// B upper/lower.
// Assumes: one captured word per cycle, in ascending sel order.
module dp_operand #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic [1:0]      cap_sel,
    input  logic            dbl,
    input  logic [DW-1:0]   word,
    output logic [2*DW-1:0] op_a,
    output logic [2*DW-1:0] op_b
);
    logic [2*DW-1:0] sext;

    assign sext = {{DW{word[DW-1]}}, word};

    // Place each returning word into its operand slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_a <= '0;
            op_b <= '0;
        end else if (cap_en) begin
            if (!dbl) begin
                if (cap_sel[0]) op_b <= sext;
                else            op_a <= sext;
            end else begin
                case (cap_sel)
                    2'd0:    op_a[2*DW-1:DW] <= word;
                    2'd1:    op_a[DW-1:0]    <= word;
                    2'd2:    op_b[2*DW-1:DW] <= word;
                    default: op_b[DW-1:0]    <= word;
                endcase
            end
        end
    end
endmodule

// File: rtl/dp_mac.sv
// Signed multiply-accumulate register.
// Adds op_a*op_b when en is high. A clear has priority over an add.
// Assumes: ACC_W >= 2*OPW. The sum wraps modulo 2^ACC_W.
module dp_mac #(
    parameter int OPW   = 32,
    parameter int ACC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [OPW-1:0]   op_a,
    input  logic [OPW-1:0]   op_b,
    output logic [ACC_W-1:0] acc
);
    logic signed [2*OPW-1:0] prod;

    assign prod = $signed(op_a) * $signed(op_b);

    // Accumulator update.
    always_ff @(posedge clk) begin
        if (!rst_n)   acc <= '0;
        else if (clr) acc <= '0;
        else if (en)  acc <= acc + ACC_W'(prod);
    end
endmodule

// File: rtl/dp_seq.sv
// Vector dot-product sequencer (top).
// A run is a fixed head phase, then one paced step per element, then a
// fixed tail phase. In an element step, reads go out in the first cycles,
// operands are captured one cycle after each read, and a single
// accumulate follows. At the end of an element, intr_req may park the run
// in a hold state until resume.
// Assumes: the memory returns data exactly one cycle after mem_rd.
// HEAD_CYC + TAIL_CYC is the fixed overhead. SGL_CYC >= 4 and DBL_CYC >= 6.
module dp_seq
    import dp_pkg::*;
#(
    parameter int DW       = 16,
    parameter int AW       = 16,
    parameter int LW       = 8,
    parameter int ACC_W    = 64,
    parameter int HEAD_CYC = 6,
    parameter int TAIL_CYC = 4,
    parameter int SGL_CYC  = 8,
    parameter int DBL_CYC  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    base_a,
    input  logic [AW-1:0]    base_b,
    input  logic [LW-1:0]    len,
    input  logic             dbl,
    input  logic             intr_req,
    input  logic             resume,
    input  logic             acc_clr,
    output logic             mem_rd,
    output logic [AW-1:0]    mem_addr,
    input  logic [DW-1:0]    mem_rdata,
    output logic             busy,
    output logic             held,
    output logic             done,
    output logic [ACC_W-1:0] acc
);
    localparam int OPW = 2 * DW;
    localparam int TW  = $clog2(HEAD_CYC + TAIL_CYC + DBL_CYC + 1);

    seq_state_t     state;
    logic [TW-1:0]  tick;
    logic [TW-1:0]  tick_m1;
    logic [TW-1:0]  elem_last;
    logic [TW-1:0]  words;
    logic [LW-1:0]  idx;
    logic [LW:0]    idx_nx;
    logic [LW-1:0]  len_q;
    logic           dbl_q;
    logic           accept;
    logic           elem_end;
    logic           cap_en;
    logic           mac_en;
    logic [OPW-1:0] op_a, op_b;

    assign accept    = (state == ST_IDLE) && start;
    assign elem_last = dbl_q ? TW'(DBL_CYC - 1) : TW'(SGL_CYC - 1);
    assign words     = dbl_q ? TW'(4) : TW'(2);
    assign tick_m1   = tick - TW'(1);
    assign idx_nx    = {1'b0, idx} + 1'b1;
    assign elem_end  = (state == ST_ELEM) && (tick == elem_last);

    // Sequencer state, phase tick, element index and latched command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tick  <= '0;
            idx   <= '0;
            len_q <= '0;
            dbl_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_HEAD;
                    tick  <= '0;
                    idx   <= '0;
                    len_q <= len;
                    dbl_q <= dbl;
                end
                ST_HEAD: begin
                    tick <= tick + TW'(1);
                    if (tick == TW'(HEAD_CYC - 1)) begin
                        tick  <= '0;
                        state <= (len_q == '0) ? ST_TAIL : ST_ELEM;
                    end
                end
                ST_ELEM: begin
                    tick <= tick + TW'(1);
                    if (elem_end) begin
                        tick <= '0;
                        idx  <= idx_nx[LW-1:0];
                        if (idx_nx == {1'b0, len_q}) state <= ST_TAIL;
                        else if (intr_req)           state <= ST_HOLD;
                    end
                end
                ST_HOLD: if (resume) begin
                    state <= ST_ELEM;
                    tick  <= '0;
                end
                ST_TAIL: begin
                    tick <= tick + TW'(1);
                    if (tick == TW'(TAIL_CYC - 1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Per-element pacing strobes and status outputs.
    always_comb begin
        mem_rd = (state == ST_ELEM) && (tick < words);
        cap_en = (state == ST_ELEM) && (tick >= TW'(1)) && (tick <= words);
        mac_en = (state == ST_ELEM) && (tick == words + TW'(1));
        busy   = (state == ST_HEAD) || (state == ST_ELEM) || (state == ST_TAIL);
        held   = (state == ST_HOLD);
        done   = (state == ST_TAIL) && (tick == TW'(TAIL_CYC - 1));
    end

    dp_addr_gen #(.AW(AW)) i_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .advance  (elem_end),
        .dbl      (dbl_q),
        .word_sel (tick[1:0]),
        .base_a   (base_a),
        .base_b   (base_b),
        .addr     (mem_addr)
    );

    dp_operand #(.DW(DW)) i_oper (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .cap_sel (tick_m1[1:0]),
        .dbl     (dbl_q),
        .word    (mem_rdata),
        .op_a    (op_a),
        .op_b    (op_b)
    );

    dp_mac #(.OPW(OPW), .ACC_W(ACC_W)) i_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr && (state == ST_IDLE)),
        .en    (mac_en),
        .op_a  (op_a),
        .op_b  (op_b),
        .acc   (acc)
    );

    // Guards on pacing, hold behaviour and command handling.
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !mem_rd); // R8
    AST_HOLD_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(acc)); // R8
    AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && len_q == '0) |-> !mem_rd); // R6
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy || held) && start) |=> ($stable(len_q) && $stable(dbl_q))); // R9
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || held) |-> (idx <= len_q)); // R4
    AST_CLR_BLOCKED_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (held && acc_clr) |=> $stable(acc)); // R10
endmodule

// File: tb/test_dp_seq.sv
// Self-checking bench: sweeps N and precision, plus hold, stray start and
// clear cases. Expected sums and cycle counts are computed arithmetically.
module test_dp_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base_a = '0, base_b = '0;
    logic [7:0]  len = '0;
    logic        dbl = 1'b0;
    logic        intr_req = 1'b0, resume = 1'b0, acc_clr = 1'b0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        busy, held, done;
    logic [63:0] acc;

    logic [15:0] mem [0:255];
    int          checks = 0;
    int          errors = 0;
    longint      exp_acc = 0;

    always #4 clk = ~clk; // 125 MHz

    dp_seq i_dp_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .base_a(base_a),
        .base_b(base_b), .len(len), .dbl(dbl), .intr_req(intr_req),
        .resume(resume), .acc_clr(acc_clr), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy),
        .held(held), .done(done), .acc(acc)
    );

    // Synchronous memory model: data one cycle after the read strobe.
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint operand(input int base, input int i, input int d);
        if (d == 0) return longint'($signed(mem[(base + i) & 255]));
        return longint'($signed({mem[(base + 2*i) & 255], mem[(base + 2*i + 1) & 255]}));
    endfunction

    task automatic run_op(input int ba, input int bb, input int n, input int d,
                          input bit do_intr, input bit poke_start, input bit poke_clr);
        longint dot = 0;
        longint first = 0;
        longint saved;
        int cycles = 0, reads = 0, dones = 0, done_at = 0;
        int epc = (d != 0) ? 16 : 8;
        bit paused = 0;
        string treq = (n == 0) ? "R6" : ((d != 0) ? "R3" : "R2");
        string areq = poke_start ? "R9" : (poke_clr ? "R10" :
                      (do_intr ? "R8" : ((n == 0) ? "R6" : ((d != 0) ? "R5" : "R4"))));
        for (int i = 0; i < n; i++) begin
            dot += operand(ba, i, d) * operand(bb, i, d);
            if (i == 0) first = dot;
        end
        @(negedge clk);
        base_a = 16'(ba); base_b = 16'(bb); len = 8'(n); dbl = d[0];
        start = 1'b1; intr_req = do_intr;
        @(negedge clk);
        start = 1'b0;
        while (busy || held) begin
            if (held) begin
                if (!paused) begin
                    check($signed(acc) == exp_acc + first, "R8 partial", $signed(acc), exp_acc + first);
                end
                paused = 1;
                intr_req = 1'b0;
                saved = $signed(acc);
                for (int k = 0; k < 5; k++) begin
                    check(held && !busy && !mem_rd && $signed(acc) == saved, "R8 hold", $signed(acc), saved);
                    start   = poke_start && (k == 1);
                    acc_clr = poke_clr && (k == 2);
                    if (start) begin base_a = 16'd3; len = 8'(n + 2); dbl = ~dbl; end
                    @(negedge clk);
                end
                start = 1'b0; acc_clr = 1'b0;
                resume = 1'b1;
                @(negedge clk);
                resume = 1'b0;
                continue;
            end
            cycles++;
            if (mem_rd) reads++;
            if (done) begin dones++; done_at = cycles; end
            start   = poke_start && (cycles == 3);
            acc_clr = poke_clr && (cycles == 4);
            if (start) begin base_b = 16'd9; len = 8'(n + 3); dbl = ~dbl; end
            @(negedge clk);
        end
        start = 1'b0; acc_clr = 1'b0; intr_req = 1'b0;
        check(cycles == 10 + epc * n, treq, cycles, 10 + epc * n);
        check(dones == 1 && done_at == cycles, "R7", done_at, cycles);
        check(reads == ((d != 0) ? 4 : 2) * n, "R11", reads, ((d != 0) ? 4 : 2) * n);
        exp_acc += dot;
        check($signed(acc) == exp_acc, areq, $signed(acc), exp_acc);
        if (do_intr && n >= 2) check(paused, "R8 entered", paused, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'((i * 40503 + 7) ^ (i << 11));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !held && !done && !mem_rd, "R1", {busy, held, done, mem_rd}, 0);
        check(acc == '0, "R1 acc", $signed(acc), 0);
        rst_n = 1'b1;
        // Sweep lengths and precisions (R2..R7, R11)
        for (int d = 0; d < 2; d++)
            for (int n = 0; n <= 6; n++)
                run_op(n * 7 + d * 50, 120 + n * 11, n, d, 0, 0, 0);
        // R10: clear while idle
        @(negedge clk); acc_clr = 1'b1;
        @(negedge clk); acc_clr = 1'b0;
        exp_acc = 0;
        check(acc == '0, "R10 idle clear", $signed(acc), 0);
        // R10: clear during busy and during hold is ignored
        run_op(17, 200, 4, 0, 0, 0, 1);
        run_op(30, 90, 3, 1, 1, 0, 1);
        // R9: start while busy, and while held
        run_op(5, 60, 5, 0, 0, 1, 0);
        run_op(40, 150, 4, 1, 1, 1, 0);
        // R8: suspend and resume in both precisions
        run_op(11, 180, 5, 0, 1, 0, 0);
        run_op(70, 20, 6, 1, 1, 0, 0);
        run_op(2, 240, 1, 0, 1, 0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule